// File: doc/BRIEF.md
# Serial EEPROM Transaction Classifier

This block watches a stream of I2C bus events that an upstream bit-level decoder has already produced. It assembles them into complete memory operations of a two-wire serial EEPROM. Each event arrives on a single-cycle strobe and carries a kind code and an 8-bit payload. When a sequence closes, the classifier emits a one-cycle result. The result holds the operation type, the word address the operation began at, the number of data bytes moved, the chip-select bits taken from the control byte, and a small warning vector.

The block also keeps a model of the memory's internal address counter. It uses that model to supply the start address of reads that carry no word address. The counter is updated whenever a memory operation is reported. Sequences that break the expected handshake are either reported as aborts or dropped without a trace.

Parameters set the number of word-address bytes (1 or 2), the page size (a power of two below 255), the number of chip-select bits in the control byte, and the counter's reset value.

Top module: `eeprom_txn_classifier`

## Requirements
- R1: Event kinds are encoded on `evKind` as 0 START, 1 repeated START, 2 STOP, 3 control byte (payload bit 0 = 1 means read), 4 data byte read, 5 data byte written, 6 ACK, 7 NACK. From idle, only a START or a repeated START arms the block, and the event after it must be a control byte.
- R2: A result is a one-cycle `resValid` pulse. It appears in the cycle after the event that completes the sequence. `resOp` is encoded as 1 byte write, 2 page write, 3 current-address read, 4 random read, 5 sequential random read, 6 device gave no reply, 7 master aborted.
- R3: The write sequence is control byte (write), word address, data bytes, STOP. It reports a byte write for exactly one data byte and a page write for more than one. With no data bytes it produces no result.
- R4: The sequence read control byte, one data byte, NACK, STOP reports a current-address read. Its start address is the address counter, its count is 1, and the counter advances by one.
- R5: The sequence write control byte, word address, repeated START, read control byte, read bytes ending in NACK, STOP reports a random read for one byte read and a sequential random read for more than one.
- R6: The word address is `ADDR_BYTES` bytes, high byte first. After a memory operation is reported, the address counter equals start address plus byte count, wrapping at 8 bits (1-byte mode) or 16 bits (2-byte mode).
- R7: A NACK to the control byte reports op 6. A STOP just after an ACKed control byte reports op 7. Both report a count of 0 and leave the address counter unchanged.
- R8: `resWarn[0]` is set on a page write whose byte count exceeds `PAGE_SIZE`.
- R9: `resWarn[1]` is set on a page write whose first and last addresses lie in different pages. Neither page warning is set for any other operation.
- R10: In a random read, a STOP that arrives where the final NACK belonged still reports the read, with `resWarn[2]` set.
- R11: A repeated START where the final STOP belonged reports the pending operation with `resWarn[3]` set. The following event is then taken as a control byte.
- R12: Any other unexpected event discards the partial sequence without a result, leaves the counter unchanged and returns to idle.
- R13: `resChip` carries the control byte's bits `CS_BITS`..1 of the sequence being reported.
- R14: After reset, `resValid` is low and the address counter equals `INIT_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Event strobe |
| evKind | input | 3 | Event kind code |
| evData | input | 8 | Event payload byte |
| resValid | output | 1 | Result pulse |
| resOp | output | 3 | Operation code |
| resAddr | output | 16 | Start word address |
| resCount | output | 8 | Data byte count, saturating |
| resWarn | output | 4 | Warning flags |
| resChip | output | CS_BITS | Chip-select bits of the control byte |
| addrCounter | output | 16 | Modelled memory address counter |

## Verification
The hardest cases to reach from the ports are the two protocol-misuse endings. One is a repeated START in place of the closing STOP, where the next event must be taken as a control byte without any new START. The other is a STOP arriving right after an ACKed read byte. The bench builds each of these from full event sequences. For the repeated START case it follows up with a second read that has no START of its own, which proves idle was skipped. Address wrap at 16 bits and a nine-byte page write that overruns both the page size and the page boundary are driven explicitly, and the bench keeps an independent counter model to check them.

// File: rtl/eeprom_txn_pkg.sv
package eeprom_txn_pkg;

  typedef enum logic [2:0] {
    EV_START  = 3'd0,
    EV_RSTART = 3'd1,
    EV_STOP   = 3'd2,
    EV_ADDR   = 3'd3,
    EV_DRD    = 3'd4,
    EV_DWR    = 3'd5,
    EV_ACK    = 3'd6,
    EV_NACK   = 3'd7
  } evKind_e;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_BYTE_WR  = 3'd1,
    OP_PAGE_WR  = 3'd2,
    OP_CUR_RD   = 3'd3,
    OP_RAND_RD  = 3'd4,
    OP_SEQ_RD   = 3'd5,
    OP_NO_REPLY = 3'd6,
    OP_ABORTED  = 3'd7
  } opCode_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic    clear;       // control byte accepted: restart tracking
    logic    addrByte;    // shift in a word-address byte
    logic    dataByte;    // one data byte moved
    logic    rewind;      // drop written bytes before a read turnaround
    logic    report;      // emit a result
    opCode_e op;
    logic    warnStop;    // STOP where NACK belonged
    logic    warnRestart; // repeated START where STOP belonged
  } dpCtl_t;

endpackage

// File: rtl/eeprom_txn_ctrl.sv
module eeprom_txn_ctrl
  import eeprom_txn_pkg::*;
#(
  parameter int ADDR_BYTES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evValid,
  input  logic [2:0] evKind,
  input  logic       rdBit,
  input  logic       countZero,
  input  logic       countOne,
  input  logic       resValid,
  output dpCtl_t     ctl
);

  localparam logic LAST_IDX = 1'(ADDR_BYTES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CTRL, S_RACK, S_RDATA, S_RNACK, S_WACK, S_WADDR, S_WAACK,
    S_WDATA, S_WDACK, S_R2CTRL, S_R2ACK, S_R2DATA, S_R2NA, S_FIN
  } state_e;

  state_e  state, nxt;
  logic    isCur, nxtCur;
  logic    addrIdx, nxtIdx;
  evKind_e kind;
  opCode_e pendOp, readOp;

  assign kind   = evKind_e'(evKind);
  assign readOp = countOne ? OP_RAND_RD : OP_SEQ_RD;
  assign pendOp = isCur ? OP_CUR_RD : readOp;

  always_comb begin
    nxt    = state;
    nxtCur = isCur;
    nxtIdx = addrIdx;
    ctl    = '0;
    ctl.op = OP_NONE;
    if (evValid) begin
      nxt = S_IDLE;
      case (state)
        S_IDLE: if (kind == EV_START || kind == EV_RSTART) nxt = S_CTRL;
        S_CTRL: if (kind == EV_ADDR) begin
          ctl.clear = 1'b1;
          nxtIdx    = 1'b0;
          nxtCur    = 1'b0;
          nxt       = rdBit ? S_RACK : S_WACK;
        end
        S_RACK, S_WACK: begin
          if (kind == EV_ACK) nxt = (state == S_RACK) ? S_RDATA : S_WADDR;
          else if (kind == EV_NACK) begin
            ctl.report = 1'b1;
            ctl.op     = OP_NO_REPLY;
          end
        end
        S_RDATA: begin
          if (kind == EV_DRD) begin
            ctl.dataByte = 1'b1;
            nxt          = S_RNACK;
          end else if (kind == EV_STOP) begin
            ctl.report = 1'b1;
            ctl.op     = OP_ABORTED;
          end
        end
        S_RNACK: if (kind == EV_NACK) begin
          nxtCur = 1'b1;
          nxt    = S_FIN;
        end
        S_WADDR: begin
          if (kind == EV_DWR) begin
            ctl.addrByte = 1'b1;
            nxt          = S_WAACK;
          end else if (kind == EV_STOP) begin
            ctl.report = 1'b1;
            ctl.op     = OP_ABORTED;
          end
        end
        S_WAACK: if (kind == EV_ACK) begin
          if (addrIdx == LAST_IDX) nxt = S_WDATA;
          else begin
            nxtIdx = addrIdx + 1'b1;
            nxt    = S_WADDR;
          end
        end
        S_WDATA: begin
          if (kind == EV_DWR) begin
            ctl.dataByte = 1'b1;
            nxt          = S_WDACK;
          end else if (kind == EV_STOP) begin
            ctl.report = !countZero;
            ctl.op     = countOne ? OP_BYTE_WR : OP_PAGE_WR;
          end else if (kind == EV_RSTART) begin
            ctl.rewind = 1'b1;
            nxt        = S_R2CTRL;
          end
        end
        S_WDACK:  if (kind == EV_ACK) nxt = S_WDATA;
        S_R2CTRL: if (kind == EV_ADDR && rdBit) nxt = S_R2ACK;
        S_R2ACK:  if (kind == EV_ACK) nxt = S_R2DATA;
        S_R2DATA: begin
          if (kind == EV_DRD) begin
            ctl.dataByte = 1'b1;
            nxt          = S_R2NA;
          end else if (kind == EV_STOP) begin
            ctl.report   = !countZero;
            ctl.op       = readOp;
            ctl.warnStop = 1'b1;
          end
        end
        S_R2NA: begin
          if (kind == EV_ACK) nxt = S_R2DATA;
          else if (kind == EV_NACK) nxt = S_FIN;
        end
        S_FIN: begin
          if (kind == EV_STOP) begin
            ctl.report = 1'b1;
            ctl.op     = pendOp;
          end else if (kind == EV_RSTART) begin
            ctl.report      = 1'b1;
            ctl.op          = pendOp;
            ctl.warnRestart = 1'b1;
            nxt             = S_CTRL;
          end
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      isCur   <= 1'b0;
      addrIdx <= 1'b0;
    end else begin
      state   <= nxt;
      isCur   <= nxtCur;
      addrIdx <= nxtIdx;
    end
  end

  // R1: from idle, only a start-type event may leave idle
  a_r1_idle_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && evValid && kind != EV_START && kind != EV_RSTART) |=> state == S_IDLE);

  // R12: sitting idle never produces a result on the next cycle
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |=> !resValid);

  // R11: a restart in place of STOP lands directly on control-byte wait
  a_r11_restart_to_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIN && evValid && kind == EV_RSTART) |=> (state == S_CTRL && resValid));

endmodule

// File: rtl/eeprom_txn_dp.sv
module eeprom_txn_dp
  import eeprom_txn_pkg::*;
#(
  parameter int          ADDR_BYTES = 1,
  parameter int          PAGE_SIZE  = 8,
  parameter int          CS_BITS    = 3,
  parameter logic [15:0] INIT_ADDR  = 16'h0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         evData,
  input  dpCtl_t             ctl,
  output logic               countZero,
  output logic               countOne,
  output logic               resValid,
  output logic [2:0]         resOp,
  output logic [15:0]        resAddr,
  output logic [7:0]         resCount,
  output logic [3:0]         resWarn,
  output logic [CS_BITS-1:0] resChip,
  output logic [15:0]        addrCounter
);

  localparam logic [15:0] ADDR_MASK = (ADDR_BYTES == 1) ? 16'h00FF : 16'hFFFF;
  localparam int          PAGE_BITS = $clog2(PAGE_SIZE);
  localparam logic [7:0]  PAGE_LIM  = 8'(PAGE_SIZE);

  logic [15:0]        startAddr, runAddr, lastAddr, shiftAddr;
  logic [7:0]         count;
  logic [CS_BITS-1:0] chip;
  logic               crossPage, overPage, isPage, isMemOp;

  assign countZero = (count == 8'd0);
  assign countOne  = (count == 8'd1);
  assign shiftAddr = {startAddr[7:0], evData} & ADDR_MASK;
  assign lastAddr  = (runAddr - 16'd1) & ADDR_MASK;
  assign crossPage = (startAddr >> PAGE_BITS) != (lastAddr >> PAGE_BITS);
  assign overPage  = count > PAGE_LIM;
  assign isPage    = (ctl.op == OP_PAGE_WR);
  assign isMemOp   = (ctl.op != OP_NONE) && (ctl.op != OP_NO_REPLY) && (ctl.op != OP_ABORTED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startAddr   <= INIT_ADDR & ADDR_MASK;
      runAddr     <= INIT_ADDR & ADDR_MASK;
      count       <= '0;
      chip        <= '0;
      resValid    <= 1'b0;
      resOp       <= OP_NONE;
      resAddr     <= '0;
      resCount    <= '0;
      resWarn     <= '0;
      resChip     <= '0;
      addrCounter <= INIT_ADDR & ADDR_MASK;
    end else begin
      resValid <= ctl.report;
      if (ctl.clear) begin
        startAddr <= addrCounter;
        runAddr   <= addrCounter;
        count     <= '0;
        chip      <= evData[CS_BITS:1];
      end
      if (ctl.addrByte) begin
        startAddr <= shiftAddr;
        runAddr   <= shiftAddr;
      end
      if (ctl.dataByte) begin
        runAddr <= (runAddr + 16'd1) & ADDR_MASK;
        count   <= (count == 8'hFF) ? count : count + 8'd1;
      end
      if (ctl.rewind) begin
        runAddr <= startAddr;
        count   <= '0;
      end
      if (ctl.report) begin
        resOp    <= ctl.op;
        resAddr  <= startAddr;
        resCount <= count;
        resWarn  <= {ctl.warnRestart, ctl.warnStop, isPage & crossPage, isPage & overPage};
        resChip  <= chip;
        if (isMemOp) addrCounter <= runAddr;
      end
    end
  end

  // R2: results are single-cycle pulses
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |=> !resValid);

  // R6: the counter only moves together with a reported result
  a_r6_counter_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addrCounter) |-> resValid);

  // R6: the counter stays inside the configured address width
  a_r6_counter_range: assert property (@(posedge clk) disable iff (!rst_n)
    (addrCounter & ~ADDR_MASK) == 16'd0);

  // R3: a byte write always carries exactly one byte
  a_r3_byte_write_one: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resOp == OP_BYTE_WR) |-> resCount == 8'd1);

  // R9: page warnings appear only on page writes
  a_r9_page_warn_only_page: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resOp != OP_PAGE_WR) |-> resWarn[1:0] == 2'b00);

  // R7: abort results carry no data
  a_r7_abort_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && (resOp == OP_NO_REPLY || resOp == OP_ABORTED)) |-> resCount == 8'd0);

endmodule

// File: rtl/eeprom_txn_classifier.sv
module eeprom_txn_classifier
  import eeprom_txn_pkg::*;
#(
  parameter int          ADDR_BYTES = 1,
  parameter int          PAGE_SIZE  = 8,
  parameter int          CS_BITS    = 3,
  parameter logic [15:0] INIT_ADDR  = 16'h0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evValid,
  input  logic [2:0]         evKind,
  input  logic [7:0]         evData,
  output logic               resValid,
  output logic [2:0]         resOp,
  output logic [15:0]        resAddr,
  output logic [7:0]         resCount,
  output logic [3:0]         resWarn,
  output logic [CS_BITS-1:0] resChip,
  output logic [15:0]        addrCounter
);

  dpCtl_t ctl;
  logic   countZero, countOne;

  eeprom_txn_ctrl #(.ADDR_BYTES(ADDR_BYTES)) uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .evValid   (evValid),
    .evKind    (evKind),
    .rdBit     (evData[0]),
    .countZero (countZero),
    .countOne  (countOne),
    .resValid  (resValid),
    .ctl       (ctl)
  );

  eeprom_txn_dp #(
    .ADDR_BYTES (ADDR_BYTES),
    .PAGE_SIZE  (PAGE_SIZE),
    .CS_BITS    (CS_BITS),
    .INIT_ADDR  (INIT_ADDR)
  ) uDp (
    .clk         (clk),
    .rst_n       (rst_n),
    .evData      (evData),
    .ctl         (ctl),
    .countZero   (countZero),
    .countOne    (countOne),
    .resValid    (resValid),
    .resOp       (resOp),
    .resAddr     (resAddr),
    .resCount    (resCount),
    .resWarn     (resWarn),
    .resChip     (resChip),
    .addrCounter (addrCounter)
  );

endmodule

// File: tb/tb_eeprom_txn_classifier.sv
`timescale 1ns/1ps
module tb_eeprom_txn_classifier;

  localparam logic [2:0] K_START = 3'd0, K_RSTART = 3'd1, K_STOP = 3'd2, K_ADDR = 3'd3,
                         K_DRD = 3'd4, K_DWR = 3'd5, K_ACK = 3'd6, K_NACK = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evValid = 1'b0;
  logic [2:0]  evKind = 3'd0;
  logic [7:0]  evData = 8'd0;
  logic        resValid;
  logic [2:0]  resOp;
  logic [15:0] resAddr;
  logic [7:0]  resCount;
  logic [3:0]  resWarn;
  logic [2:0]  resChip;
  logic [15:0] addrCounter;

  int nChecks = 0;
  int nFail   = 0;
  int spur    = 0;
  logic [15:0] expCnt = 16'h0120;

  always #4 clk = ~clk;

  eeprom_txn_classifier #(
    .ADDR_BYTES(2), .PAGE_SIZE(8), .CS_BITS(3), .INIT_ADDR(16'h0120)
  ) dut (
    .clk(clk), .rst_n(rst_n), .evValid(evValid), .evKind(evKind), .evData(evData),
    .resValid(resValid), .resOp(resOp), .resAddr(resAddr), .resCount(resCount),
    .resWarn(resWarn), .resChip(resChip), .addrCounter(addrCounter)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One event per call; the result of that event is visible on return
  task automatic send(input logic [2:0] k, input logic [7:0] d, input logic expPulse);
    @(negedge clk);
    evValid = 1'b1; evKind = k; evData = d;
    @(negedge clk);
    evValid = 1'b0;
    if (resValid !== expPulse) spur++;
  endtask

  task automatic checkRes(input string tag, input int op, input int addr, input int cnt,
                          input int warn);
    chk({tag, " valid"}, int'(resValid), 1);
    chk({tag, " op"}, int'(resOp), op);
    chk({tag, " addr"}, int'(resAddr), addr);
    chk({tag, " count"}, int'(resCount), cnt);
    chk({tag, " warn"}, int'(resWarn), warn);
    chk({tag, " stray"}, spur, 0);
    spur = 0;
  endtask

  task automatic writeHead(input logic [7:0] ctrl, input logic [15:0] addr);
    send(K_START, 8'h00, 1'b0);
    send(K_ADDR, ctrl, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_DWR, addr[15:8], 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_DWR, addr[7:0], 1'b0);
    send(K_ACK, 8'h00, 1'b0);
  endtask

  task automatic tReset;
    chk("R14 resValid after reset", int'(resValid), 0);
    chk("R14 counter after reset", int'(addrCounter), 16'h0120);
  endtask

  task automatic tCurRead(input string tag, input logic [2:0] startKind);
    send(startKind, 8'h00, 1'b0);
    send(K_ADDR, 8'hA5, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_DRD, 8'h5A, 1'b0);
    send(K_NACK, 8'h00, 1'b0);
    send(K_STOP, 8'h00, 1'b1);
    checkRes(tag, 3, expCnt, 1, 0);
    chk({tag, " R13 chip"}, int'(resChip), 2);
    expCnt = expCnt + 16'd1;
    chk({tag, " counter"}, int'(addrCounter), expCnt);
  endtask

  task automatic tByteWrite;
    writeHead(8'hA6, 16'h0234);
    send(K_DWR, 8'h55, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_STOP, 8'h00, 1'b1);
    checkRes("R3 R6 byte write", 1, 16'h0234, 1, 0);
    chk("R13 chip on write", int'(resChip), 3);
    expCnt = 16'h0235;
    chk("R6 counter after byte write", int'(addrCounter), expCnt);
  endtask

  task automatic tPageWrite(input string tag, input logic [15:0] addr, input int n,
                            input int warn);
    writeHead(8'hA0, addr);
    for (int i = 0; i < n; i++) begin
      send(K_DWR, 8'(i), 1'b0);
      send(K_ACK, 8'h00, 1'b0);
    end
    send(K_STOP, 8'h00, 1'b1);
    checkRes(tag, 2, addr, n, warn);
    expCnt = addr + 16'(n);
    chk({tag, " counter"}, int'(addrCounter), expCnt);
  endtask

  task automatic tEmptyWrite;
    writeHead(8'hA0, 16'h0777);
    send(K_STOP, 8'h00, 1'b0);
    chk("R3 empty write no result", spur, 0);
    spur = 0;
    chk("R3 empty write counter kept", int'(addrCounter), expCnt);
  endtask

  task automatic tRandRead(input string tag, input logic [15:0] addr, input int n);
    writeHead(8'hA0, addr);
    send(K_RSTART, 8'h00, 1'b0);
    send(K_ADDR, 8'hA1, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    for (int i = 0; i < n; i++) begin
      send(K_DRD, 8'hC0 + 8'(i), 1'b0);
      send((i == n - 1) ? K_NACK : K_ACK, 8'h00, 1'b0);
    end
    send(K_STOP, 8'h00, 1'b1);
    checkRes(tag, (n == 1) ? 4 : 5, addr, n, 0);
    expCnt = addr + 16'(n);
    chk({tag, " counter"}, int'(addrCounter), expCnt);
  endtask

  task automatic tAborts;
    send(K_START, 8'h00, 1'b0);
    send(K_ADDR, 8'hA0, 1'b0);
    send(K_NACK, 8'h00, 1'b1);
    chk("R7 no reply op", int'(resOp), 6);
    chk("R7 no reply count", int'(resCount), 0);
    chk("R7 no reply counter kept", int'(addrCounter), expCnt);
    send(K_START, 8'h00, 1'b0);
    send(K_ADDR, 8'hA1, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_STOP, 8'h00, 1'b1);
    chk("R7 master abort op", int'(resOp), 7);
    chk("R7 master abort counter kept", int'(addrCounter), expCnt);
    chk("R7 stray", spur, 0);
    spur = 0;
  endtask

  task automatic tStopForNack;
    writeHead(8'hA0, 16'h0300);
    send(K_RSTART, 8'h00, 1'b0);
    send(K_ADDR, 8'hA1, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_DRD, 8'h11, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_STOP, 8'h00, 1'b1);
    checkRes("R10 stop for nack", 4, 16'h0300, 1, 4'b0100);
    expCnt = 16'h0301;
    chk("R10 counter", int'(addrCounter), expCnt);
  endtask

  task automatic tRestartForStop;
    send(K_START, 8'h00, 1'b0);
    send(K_ADDR, 8'hA1, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_DRD, 8'h22, 1'b0);
    send(K_NACK, 8'h00, 1'b0);
    send(K_RSTART, 8'h00, 1'b1);
    checkRes("R11 restart for stop", 3, expCnt, 1, 4'b1000);
    expCnt = expCnt + 16'd1;
    // no new START: the next event must be taken as a control byte
    send(K_ADDR, 8'hA1, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_DRD, 8'h33, 1'b0);
    send(K_NACK, 8'h00, 1'b0);
    send(K_STOP, 8'h00, 1'b1);
    checkRes("R11 follow-on read", 3, expCnt, 1, 0);
    expCnt = expCnt + 16'd1;
  endtask

  task automatic tUnexpected;
    send(K_STOP, 8'h00, 1'b0);
    send(K_ADDR, 8'hA1, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_DRD, 8'h00, 1'b0);
    send(K_NACK, 8'h00, 1'b0);
    send(K_STOP, 8'h00, 1'b0);
    chk("R1 idle ignores non-start", spur, 0);
    spur = 0;
    send(K_START, 8'h00, 1'b0);
    send(K_DWR, 8'hA0, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_STOP, 8'h00, 1'b0);
    chk("R1 non-control after start", spur, 0);
    spur = 0;
    writeHead(8'hA0, 16'h0400);
    send(K_DWR, 8'h01, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_ACK, 8'h00, 1'b0);
    send(K_STOP, 8'h00, 1'b0);
    chk("R12 discarded no result", spur, 0);
    spur = 0;
    chk("R12 counter kept", int'(addrCounter), expCnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tCurRead("R4 current read", K_START);
    tByteWrite();
    tPageWrite("R3 page write", 16'h0010, 3, 0);
    tPageWrite("R9 page cross", 16'h0006, 4, 4'b0010);
    tPageWrite("R8 R9 page overrun", 16'h0000, 9, 4'b0011);
    tPageWrite("R8 full page exact", 16'h0008, 8, 0);
    tEmptyWrite();
    tRandRead("R5 random read", 16'h0100, 1);
    tRandRead("R5 R6 sequential wrap", 16'hFFFE, 3);
    chk("R6 wrapped counter", int'(addrCounter), 16'h0001);
    tAborts();
    tStopForNack();
    tRestartForStop();
    tUnexpected();
    tCurRead("R1 R12 restart arms", K_RSTART);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired R2 actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule